// File: doc/BRIEF.md
# SPI Byte Buffer and Status Front End

This block sits between a processor or a DMA stream and the shift engine of an SPI port. It keeps outgoing bytes in a four-entry egress FIFO and incoming bytes in a four-entry ingress FIFO. From the occupancy of these FIFOs it derives level status flags. Each flag's rising edge, and each error event, is latched into a pending register whose bits are cleared by writing 1 to them. A mask selects which flag bits can raise the single interrupt line. Error bits always raise it.

In register mode the processor pushes one byte per write strobe and pops one byte per read strobe. Transfers in this mode have no length, so the end-of-transfer flags stay low. In DMA mode the FIFOs connect instead to a valid/ready byte stream on each side. A start pulse arms two byte counters. When the programmed number of bytes has left the egress FIFO toward the engine, the transmit done flag is raised. When the programmed number of bytes has arrived from the engine, the receive done flag is raised. A bit-order option reverses every byte on the engine side, so that the engine, which always shifts bit 7 first, sends and receives the least significant bit first. Separate flush strobes empty each FIFO.

Top module: `spi_byte_front`

## Requirements
- R1: After reset both FIFOs are empty, `status_o` equals 6'b000011, `irq_pend_o` is 0, `irq_o` is 0, and both DMA stream outputs are low.
- R2: Each FIFO holds 4 bytes and delivers them in arrival order. A push into a full FIFO is dropped and leaves the stored bytes unchanged.
- R3: `status_o[0]` is high exactly when the egress FIFO is not full. `status_o[1]` is high exactly when the egress FIFO has 2 or more free entries.
- R4: `status_o[3]` is high exactly when the ingress FIFO holds at least 1 byte. `status_o[4]` is high exactly when it holds 2 or more bytes.
- R5: With `cfg_lsb_first_i` high, `eng_tx_data_o` is the bit-reverse of the head egress byte, and a received engine byte is stored bit-reversed. With it low, bytes pass through unchanged.
- R6: A flush strobe empties its FIFO at the next clock edge and takes priority over a push or pop in the same cycle.
- R7: In register mode (`cfg_dma_i` low), `reg_wr_i` pushes egress and `reg_rd_i` pops ingress. `dma_tx_ready_o` and `dma_rx_valid_o` stay low. `status_o[2]` and `status_o[5]` stay low even after a start pulse with a zero count.
- R8: In DMA mode, egress bytes enter only through the `dma_tx_*` handshake and ingress bytes leave only through the `dma_rx_*` handshake. `reg_wr_i` is ignored.
- R9: In DMA mode, after `xfer_start_i` loads `tx_count_i` = N, `status_o[2]` becomes high once N bytes have been popped by the engine (immediately if N = 0) and stays high until the next start.
- R10: In DMA mode, after `xfer_start_i` loads `rx_count_i` = N, `status_o[5]` becomes high once N bytes have arrived on `eng_rx_valid_i`.
- R11: A register write to a full egress FIFO sets `irq_pend_o[6]`. An engine request on an empty egress FIFO sets `irq_pend_o[7]`. An engine byte arriving at a full ingress FIFO sets `irq_pend_o[8]`. Each of these sets `irq_o` whatever `irq_mask_i` holds.
- R12: `irq_pend_o[5:0]` latch the rising edge of `status_o[5:0]` one cycle after it. A 1 in `irq_clr_i` clears the matching bit. `irq_o` also rises when a pending flag bit has its mask bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_dma_i | input | 1 | 1 = DMA mode, 0 = register mode |
| cfg_lsb_first_i | input | 1 | Reverse bit order on the engine side |
| tx_flush_i | input | 1 | Empty the egress FIFO |
| rx_flush_i | input | 1 | Empty the ingress FIFO |
| xfer_start_i | input | 1 | Load byte counts and arm end-of-transfer detection |
| tx_count_i | input | CNT_W | Egress byte count for DMA mode |
| rx_count_i | input | CNT_W | Ingress byte count for DMA mode |
| reg_wr_i | input | 1 | Register-mode egress write strobe |
| reg_wdata_i | input | 8 | Register-mode egress byte |
| reg_rd_i | input | 1 | Register-mode ingress read strobe |
| reg_rdata_o | output | 8 | Head of the ingress FIFO |
| dma_tx_valid_i | input | 1 | Egress stream valid |
| dma_tx_data_i | input | 8 | Egress stream byte |
| dma_tx_ready_o | output | 1 | Egress stream ready |
| dma_rx_valid_o | output | 1 | Ingress stream valid |
| dma_rx_data_o | output | 8 | Ingress stream byte |
| dma_rx_ready_i | input | 1 | Ingress stream ready |
| eng_tx_req_i | input | 1 | Engine takes the head egress byte |
| eng_tx_data_o | output | 8 | Byte offered to the engine |
| eng_rx_valid_i | input | 1 | Engine delivers a received byte |
| eng_rx_data_i | input | 8 | Received byte from the engine |
| irq_mask_i | input | 6 | Interrupt enables for the flag bits |
| irq_clr_i | input | 9 | Write-1-to-clear strobes for the pending bits |
| status_o | output | 6 | Level flags: space, half-free, tx done, data, half-full, rx done |
| irq_pend_o | output | 9 | Pending flag edges [5:0] and errors [8:6] |
| irq_o | output | 1 | Interrupt request |

## Verification
On every cycle the assertions check the following. FIFO occupancy never passes the depth. A push into a full FIFO without a pop leaves the occupancy unchanged. A flush leaves the FIFO empty. The counters never run past their target. Every error event and every flag rising edge shows up in the pending register one cycle later. A register write in DMA mode never changes the egress occupancy. The bench scenarios cover what a property cannot express over the ports alone: byte order through the FIFOs, bit reversal of a range of byte values, the flag values at each fill level from empty to full, the done flags for a sweep of programmed counts, and the effect of the mask and the clear strobes on the interrupt line.

// File: rtl/spi_byte_front_pkg.sv
`timescale 1ns/1ps
package spi_byte_front_pkg;
  localparam int unsigned NUM_FLAGS = 6;
  localparam int unsigned NUM_ERRS  = 3;

  localparam int unsigned ST_TX_SPACE = 0;
  localparam int unsigned ST_TX_HALF  = 1;
  localparam int unsigned ST_TX_DONE  = 2;
  localparam int unsigned ST_RX_DATA  = 3;
  localparam int unsigned ST_RX_HALF  = 4;
  localparam int unsigned ST_RX_DONE  = 5;

  // flag values with both FIFOs empty
  localparam logic [NUM_FLAGS-1:0] ST_RESET = 6'b000011;

  function automatic logic [7:0] flip_byte(input logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = b[7-i];
    return r;
  endfunction
endpackage

// File: rtl/spi_fq_fifo.sv
`timescale 1ns/1ps
module spi_fq_fifo #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          push_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          pop_i,
  output logic [DW-1:0] rdata_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign rdata_o = mem_q[rd_q];
  assign count_o = cnt_q;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= nxt(wr_q);
      if (do_pop)  rd_q <= nxt(rd_q);
      if (do_push && !do_pop)      cnt_q <= cnt_q + CW'(1);
      else if (do_pop && !do_push) cnt_q <= cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push && !clr_i) mem_q[wr_q] <= wdata_i;
  end

  // R2
  fifo_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));

  // R2
  full_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !pop_i && !clr_i) |=> $stable(count_o));

  // R6
  flush_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> empty_o);
endmodule

// File: rtl/spi_fq_xcnt.sv
`timescale 1ns/1ps
module spi_fq_xcnt #(
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          dma_i,
  input  logic [CW-1:0] target_i,
  input  logic          step_i,
  output logic          done_o
);
  logic [CW-1:0] cnt_q, tgt_q;
  logic          armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      tgt_q   <= '0;
      armed_q <= 1'b0;
    end else if (start_i) begin
      cnt_q   <= '0;
      tgt_q   <= target_i;
      armed_q <= dma_i;
    end else if (armed_q && step_i && cnt_q != tgt_q) begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  // counters only terminate a DMA transfer
  assign done_o = dma_i && armed_q && (cnt_q == tgt_q);

  // R9
  cnt_le_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |-> cnt_q <= tgt_q);
endmodule

// File: rtl/spi_fq_irq.sv
`timescale 1ns/1ps
module spi_fq_irq
  import spi_byte_front_pkg::*;
#(
  parameter int unsigned NF = NUM_FLAGS,
  parameter int unsigned NE = NUM_ERRS,
  parameter logic [NF-1:0] RST_FLAGS = ST_RESET
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NF-1:0]    status_i,
  input  logic [NE-1:0]    err_i,
  input  logic [NF-1:0]    mask_i,
  input  logic [NF+NE-1:0] clr_i,
  output logic [NF+NE-1:0] pend_o,
  output logic             irq_o
);
  logic [NF-1:0]    prev_q;
  logic [NF+NE-1:0] pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= RST_FLAGS;
      pend_q <= '0;
    end else begin
      prev_q <= status_i;
      pend_q <= (pend_q & ~clr_i) | {err_i, status_i & ~prev_q};
    end
  end

  assign pend_o = pend_q;
  // errors bypass the mask
  assign irq_o  = (|(pend_q[NF-1:0] & mask_i)) | (|pend_q[NF+:NE]);

  for (genvar k = 0; k < NE; k++) begin : g_err_chk
    // R11
    err_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      err_i[k] |=> pend_o[NF+k]);
  end

  for (genvar k = 0; k < NF; k++) begin : g_edge_chk
    // R12
    edge_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(status_i[k]) |=> pend_o[k]);
  end

  // R11
  err_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_i != '0) |=> irq_o);
endmodule

// File: rtl/spi_byte_front.sv
`timescale 1ns/1ps
module spi_byte_front
  import spi_byte_front_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 4,
  parameter int unsigned CNT_W      = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     cfg_dma_i,
  input  logic                     cfg_lsb_first_i,
  input  logic                     tx_flush_i,
  input  logic                     rx_flush_i,
  input  logic                     xfer_start_i,
  input  logic [CNT_W-1:0]         tx_count_i,
  input  logic [CNT_W-1:0]         rx_count_i,
  input  logic                     reg_wr_i,
  input  logic [7:0]               reg_wdata_i,
  input  logic                     reg_rd_i,
  output logic [7:0]               reg_rdata_o,
  input  logic                     dma_tx_valid_i,
  input  logic [7:0]               dma_tx_data_i,
  output logic                     dma_tx_ready_o,
  output logic                     dma_rx_valid_o,
  output logic [7:0]               dma_rx_data_o,
  input  logic                     dma_rx_ready_i,
  input  logic                     eng_tx_req_i,
  output logic [7:0]               eng_tx_data_o,
  input  logic                     eng_rx_valid_i,
  input  logic [7:0]               eng_rx_data_i,
  input  logic [NUM_FLAGS-1:0]     irq_mask_i,
  input  logic [NUM_FLAGS+NUM_ERRS-1:0] irq_clr_i,
  output logic [NUM_FLAGS-1:0]     status_o,
  output logic [NUM_FLAGS+NUM_ERRS-1:0] irq_pend_o,
  output logic                     irq_o
);
  localparam int unsigned FW   = $clog2(FIFO_DEPTH + 1);
  localparam logic [FW-1:0] DEP  = FW'(FIFO_DEPTH);
  localparam logic [FW-1:0] HALF = FW'(FIFO_DEPTH / 2);

  logic [FW-1:0] tx_cnt, rx_cnt;
  logic          tx_full, tx_empty, rx_full, rx_empty;
  logic          tx_push, tx_pop, rx_pop;
  logic [7:0]    tx_wdata, tx_head, rx_wdata, rx_head;
  logic          tx_done, rx_done;
  logic [NUM_ERRS-1:0] err;

  assign tx_push  = cfg_dma_i ? dma_tx_valid_i : reg_wr_i;
  assign tx_wdata = cfg_dma_i ? dma_tx_data_i  : reg_wdata_i;
  assign tx_pop   = eng_tx_req_i;
  assign rx_pop   = cfg_dma_i ? dma_rx_ready_i : reg_rd_i;
  assign rx_wdata = cfg_lsb_first_i ? flip_byte(eng_rx_data_i) : eng_rx_data_i;

  spi_fq_fifo #(.DW(8), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
    .clk_i, .rst_ni,
    .clr_i   (tx_flush_i),
    .push_i  (tx_push),
    .wdata_i (tx_wdata),
    .pop_i   (tx_pop),
    .rdata_o (tx_head),
    .count_o (tx_cnt),
    .full_o  (tx_full),
    .empty_o (tx_empty)
  );

  spi_fq_fifo #(.DW(8), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
    .clk_i, .rst_ni,
    .clr_i   (rx_flush_i),
    .push_i  (eng_rx_valid_i),
    .wdata_i (rx_wdata),
    .pop_i   (rx_pop),
    .rdata_o (rx_head),
    .count_o (rx_cnt),
    .full_o  (rx_full),
    .empty_o (rx_empty)
  );

  assign dma_tx_ready_o = cfg_dma_i && !tx_full;
  assign dma_rx_valid_o = cfg_dma_i && !rx_empty;
  assign dma_rx_data_o  = rx_head;
  assign reg_rdata_o    = rx_head;
  assign eng_tx_data_o  = cfg_lsb_first_i ? flip_byte(tx_head) : tx_head;

  spi_fq_xcnt #(.CW(CNT_W)) u_tx_xcnt (
    .clk_i, .rst_ni,
    .start_i  (xfer_start_i),
    .dma_i    (cfg_dma_i),
    .target_i (tx_count_i),
    .step_i   (eng_tx_req_i && !tx_empty),
    .done_o   (tx_done)
  );

  spi_fq_xcnt #(.CW(CNT_W)) u_rx_xcnt (
    .clk_i, .rst_ni,
    .start_i  (xfer_start_i),
    .dma_i    (cfg_dma_i),
    .target_i (rx_count_i),
    .step_i   (eng_rx_valid_i),
    .done_o   (rx_done)
  );

  always_comb begin
    status_o              = '0;
    status_o[ST_TX_SPACE] = !tx_full;
    status_o[ST_TX_HALF]  = (DEP - tx_cnt) >= HALF;
    status_o[ST_TX_DONE]  = tx_done;
    status_o[ST_RX_DATA]  = !rx_empty;
    status_o[ST_RX_HALF]  = rx_cnt >= HALF;
    status_o[ST_RX_DONE]  = rx_done;
  end

  // [0] register-write overflow, [1] engine underflow, [2] receive overflow
  assign err[0] = !cfg_dma_i && reg_wr_i && tx_full;
  assign err[1] = eng_tx_req_i && tx_empty;
  assign err[2] = eng_rx_valid_i && rx_full;

  spi_fq_irq #(.NF(NUM_FLAGS), .NE(NUM_ERRS), .RST_FLAGS(ST_RESET)) u_irq (
    .clk_i, .rst_ni,
    .status_i (status_o),
    .err_i    (err),
    .mask_i   (irq_mask_i),
    .clr_i    (irq_clr_i),
    .pend_o   (irq_pend_o),
    .irq_o    (irq_o)
  );

  // R8
  reg_wr_dma_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_dma_i && reg_wr_i && !dma_tx_valid_i && !eng_tx_req_i && !tx_flush_i)
      |=> $stable(tx_cnt));
endmodule

// File: tb/spi_byte_front_tb.sv
`timescale 1ns/1ps
module spi_byte_front_tb;
  localparam int CNT_W = 16;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic cfg_dma_i = 0, cfg_lsb_first_i = 0, tx_flush_i = 0, rx_flush_i = 0;
  logic xfer_start_i = 0;
  logic [CNT_W-1:0] tx_count_i = '0, rx_count_i = '0;
  logic reg_wr_i = 0, reg_rd_i = 0;
  logic [7:0] reg_wdata_i = '0, reg_rdata_o;
  logic dma_tx_valid_i = 0, dma_tx_ready_o, dma_rx_valid_o, dma_rx_ready_i = 0;
  logic [7:0] dma_tx_data_i = '0, dma_rx_data_o;
  logic eng_tx_req_i = 0, eng_rx_valid_i = 0;
  logic [7:0] eng_tx_data_o, eng_rx_data_i = '0;
  logic [5:0] irq_mask_i = '0;
  logic [8:0] irq_clr_i = '0;
  logic [5:0] status_o;
  logic [8:0] irq_pend_o;
  logic irq_o;

  int checks = 0;
  int failures = 0;

  always #2.5 clk_i = ~clk_i;

  spi_byte_front #(.FIFO_DEPTH(4), .CNT_W(CNT_W)) u_dut (.*);

  function automatic logic [7:0] rev8(input logic [7:0] b);
    logic [7:0] r = '0;
    for (int i = 0; i < 8; i++) if (b[i]) r = r | (8'h80 >> i);
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk_i);
  endtask

  task automatic clear_pend();
    irq_clr_i = '1; tick(); irq_clr_i = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_ni = 1'b1;
    // R1 reset state
    chk("R1 status", status_o, 6'b000011);
    chk("R1 pend", irq_pend_o, 0);
    chk("R1 irq", irq_o, 0);
    chk("R1 dma outs", {dma_tx_ready_o, dma_rx_valid_o}, 0);
    tick();

    // R2/R3 egress fill sweep in register mode, then overflow
    for (int k = 0; k < 5; k++) begin
      int c;
      reg_wr_i = 1; reg_wdata_i = 8'h10 + 8'(k); tick(); reg_wr_i = 0;
      c = (k + 1 > 4) ? 4 : k + 1;
      chk("R3 tx_space", status_o[0], (c < 4));
      chk("R3 tx_half", status_o[1], (4 - c >= 2));
    end
    chk("R11 tx overflow pend", irq_pend_o[6], 1);
    chk("R11 irq unmasked", irq_o, 1);
    for (int k = 0; k < 4; k++) begin
      chk("R2 tx order", eng_tx_data_o, 8'h10 + 8'(k));
      eng_tx_req_i = 1; tick(); eng_tx_req_i = 0;
    end
    chk("R2 tx empty flags", status_o[1:0], 2'b11);
    eng_tx_req_i = 1; tick(); eng_tx_req_i = 0;
    chk("R11 underflow pend", irq_pend_o[7], 1);
    clear_pend();
    chk("R12 w1c all", irq_pend_o, 0);
    chk("R12 irq low", irq_o, 0);

    // R4 ingress fill sweep and overflow
    for (int k = 0; k < 5; k++) begin
      int c;
      eng_rx_valid_i = 1; eng_rx_data_i = 8'hA0 + 8'(k); tick(); eng_rx_valid_i = 0;
      c = (k + 1 > 4) ? 4 : k + 1;
      chk("R4 rx_data", status_o[3], (c >= 1));
      chk("R4 rx_half", status_o[4], (c >= 2));
    end
    chk("R11 rx overflow pend", irq_pend_o[8], 1);
    for (int k = 0; k < 4; k++) begin
      chk("R2 rx order", reg_rdata_o, 8'hA0 + 8'(k));
      reg_rd_i = 1; tick(); reg_rd_i = 0;
    end
    chk("R7 rx empty", status_o[4:3], 2'b00);
    clear_pend();

    // R5 bit order sweep, both directions
    for (int lsb = 0; lsb < 2; lsb++) begin
      cfg_lsb_first_i = 1'(lsb);
      for (int v = 0; v < 256; v += 17) begin
        reg_wr_i = 1; reg_wdata_i = 8'(v); tick(); reg_wr_i = 0;
        chk("R5 tx bit order", eng_tx_data_o, lsb ? rev8(8'(v)) : 8'(v));
        eng_tx_req_i = 1; tick(); eng_tx_req_i = 0;
        eng_rx_valid_i = 1; eng_rx_data_i = 8'(v); tick(); eng_rx_valid_i = 0;
        chk("R5 rx bit order", reg_rdata_o, lsb ? rev8(8'(v)) : 8'(v));
        reg_rd_i = 1; tick(); reg_rd_i = 0;
      end
    end
    cfg_lsb_first_i = 0;

    // R6 flush beats a same-cycle push
    for (int k = 0; k < 3; k++) begin
      reg_wr_i = 1; eng_rx_valid_i = 1; tick();
    end
    chk("R6 filled", status_o[4:3], 2'b11);
    tx_flush_i = 1; rx_flush_i = 1; tick();
    tx_flush_i = 0; rx_flush_i = 0; reg_wr_i = 0; eng_rx_valid_i = 0;
    chk("R6 flushed", status_o, 6'b000011);
    clear_pend();

    // R12 edge latch, mask and clear
    eng_rx_valid_i = 1; eng_rx_data_i = 8'h5C; tick(); eng_rx_valid_i = 0;
    chk("R12 latency", irq_pend_o[3], 0);
    tick();
    chk("R12 rx_data edge", irq_pend_o[3], 1);
    chk("R12 masked off", irq_o, 0);
    irq_mask_i = 6'b001000;
    #1 chk("R12 mask on", irq_o, 1);
    irq_clr_i = 9'h008; tick(); irq_clr_i = 0;
    chk("R12 w1c bit", irq_pend_o[3], 0);
    chk("R12 irq cleared", irq_o, 0);
    irq_mask_i = 0;
    reg_rd_i = 1; tick(); reg_rd_i = 0;

    // R7 register mode never terminates
    tx_count_i = 0; rx_count_i = 0; xfer_start_i = 1; tick(); xfer_start_i = 0;
    chk("R7 no done", {status_o[5], status_o[2]}, 0);
    chk("R7 dma idle", {dma_tx_ready_o, dma_rx_valid_o}, 0);

    // R9 DMA egress count sweep
    cfg_dma_i = 1; rx_count_i = 16'd100;
    for (int n = 0; n < 5; n++) begin
      tx_count_i = 16'(n); xfer_start_i = 1; tick(); xfer_start_i = 0;
      chk("R9 done at start", status_o[2], (n == 0));
      for (int k = 1; k <= n; k++) begin
        chk("R8 dma ready", dma_tx_ready_o, 1);
        dma_tx_valid_i = 1; dma_tx_data_i = 8'(k); tick(); dma_tx_valid_i = 0;
        chk("R8 dma byte", eng_tx_data_o, 8'(k));
        eng_tx_req_i = 1; tick(); eng_tx_req_i = 0;
        chk("R9 tx done", status_o[2], (k == n));
      end
    end
    clear_pend();

    // R8 register write ignored in DMA mode: next engine request underflows
    reg_wr_i = 1; reg_wdata_i = 8'h77; tick(); reg_wr_i = 0;
    eng_tx_req_i = 1; tick(); eng_tx_req_i = 0;
    chk("R8 reg write ignored", irq_pend_o[7:6], 2'b10);
    clear_pend();

    // R10 DMA ingress count
    rx_count_i = 16'd3; xfer_start_i = 1; tick(); xfer_start_i = 0;
    for (int k = 1; k <= 3; k++) begin
      eng_rx_valid_i = 1; eng_rx_data_i = 8'hC0 + 8'(k); tick(); eng_rx_valid_i = 0;
      chk("R10 rx done", status_o[5], (k == 3));
    end
    for (int k = 1; k <= 3; k++) begin
      chk("R8 dma rx valid", dma_rx_valid_o, 1);
      chk("R8 dma rx data", dma_rx_data_o, 8'hC0 + 8'(k));
      dma_rx_ready_i = 1; tick(); dma_rx_ready_i = 0;
    end
    chk("R8 dma rx drained", dma_rx_valid_o, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule